// File: doc/BRIEF.md
# Victim Line Buffer

A small fully-associative store that sits beside a direct-mapped first-level cache, on the path between that cache and its refill from the next memory level. When the main cache misses, the surrounding controller presents the missing line address. It also presents the line that now occupies the conflicting main-cache slot. Every valid entry is compared against the full line address at once. The answer is returned on the following cycle, which makes a buffer hit a one-cycle penalty with no trip to the next level.

In victim mode (`MISS_MODE = 0`), a hit exchanges lines. The found line leaves the buffer and goes back to the main cache, and the displaced main-cache line takes its entry. When a miss is serviced from memory, the controller uses the insert port to offer the line pushed out of the main cache. An empty main-cache slot produces no insertion. In miss-cache mode (`MISS_MODE = 1`), the refilled line itself is copied into the buffer, and hits leave entries where they are. Entries are replaced least-recently-used, and one flush input empties the buffer in a single cycle.

Control is a three-state machine. `IDLE` means no response is due. `HIT_RSP` means a hit answer is on the outputs. `MISS_RSP` means a miss answer is on the outputs. Every state moves, on each clock, as follows:
- To `HIT_RSP` on an accepted lookup that matches.
- To `MISS_RSP` on an accepted lookup that does not match.
- Otherwise back to `IDLE`.

Flush and reset both force `IDLE`.

Top module: `victim_line_buffer`

## Requirements
- R1: After reset no response is presented (`rsp_valid_o` = 0) and every entry is empty, so a first lookup answers a miss.
- R2: An accepted lookup (`lk_valid_i` = 1, `flush_i` = 0) yields `rsp_valid_o` = 1 in exactly the next cycle and in no other; with no accepted lookup `rsp_valid_o` stays 0.
- R3: A lookup hits if and only if a valid entry holds the same full line address; on a hit `rsp_data_o` carries that entry's data, on a miss it is 0.
- R4: In victim mode a hit moves the found line out of the buffer and writes the offered evicted line (`ev_*`) into the same entry when `ev_valid_i` = 1; a repeated lookup of the returned address then misses and the evicted address hits.
- R5: In victim mode an insert stores the evicted line (`ev_addr_i`, `ev_data_i`), and is suppressed when `ev_valid_i` = 0; the fill line is not stored.
- R6: In miss-cache mode an insert stores the fill line (`fill_addr_i`, `fill_data_i`) regardless of `ev_valid_i`, and a hit leaves the entry in place.
- R7: An insert fills the lowest-numbered empty entry, else the least recently used one; a hit that keeps or rewrites an entry, and every insert, make that entry most recent.
- R8: `flush_i` empties all entries in one cycle and overrides a lookup or an insert of the same cycle, which produce no response and no store.
- R9: An insert presented in the same cycle as a lookup is dropped.
- R10: An insert alone never produces a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Empty all entries |
| lk_valid_i | input | 1 | Lookup request after a main-cache miss |
| lk_addr_i | input | LINE_AW | Line address looked up |
| ev_valid_i | input | 1 | Conflicting main-cache slot holds a line |
| ev_addr_i | input | LINE_AW | Line address in the conflicting slot |
| ev_data_i | input | DATA_W | Line data in the conflicting slot |
| ins_valid_i | input | 1 | Insert request after a refill from memory |
| fill_addr_i | input | LINE_AW | Refilled line address |
| fill_data_i | input | DATA_W | Refilled line data |
| rsp_valid_o | output | 1 | Lookup answer present |
| rsp_hit_o | output | 1 | Answer is a hit |
| rsp_data_o | output | DATA_W | Line data on a hit, else 0 |

## Verification
A lookup's answer is due one cycle after the edge that accepts it. The bench drives each request on a falling edge, lets one rising edge pass, and reads `rsp_*` on the following falling edge. Inserts and flushes change stored state at the accepting edge. Their effect is therefore checked by later lookups, while the absence of a response is read on the falling edge after the insert. A bench model of a four-set direct-mapped cache and the buffer supplies the expected hit flag and data for each lookup in a conflict-heavy address sequence.

// File: rtl/vlb_pkg.sv
package vlb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_HIT_RSP  = 2'd1,
        ST_MISS_RSP = 2'd2
    } vlb_state_e;
endpackage

// File: rtl/vlb_match.sv
module vlb_match #(
    parameter int ENTRIES = 4,
    parameter int LINE_AW = 12,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ENTRIES-1:0]  vld_i,
    input  logic [LINE_AW-1:0]  tag_i [ENTRIES],
    input  logic [LINE_AW-1:0]  addr_i,
    output logic                hit_o,
    output logic [IDX_W-1:0]    idx_o
);
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld_i[g] && (tag_i[g] == addr_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx_o = IDX_W'(i);
        end
    end

    assign hit_o = |match;

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R3
endmodule

// File: rtl/vlb_lru.sv
module vlb_lru #(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_i,
    input  logic [IDX_W-1:0]   touch_idx_i,
    input  logic [ENTRIES-1:0] vld_i,
    output logic [IDX_W-1:0]   repl_idx_o
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0]   age_q [ENTRIES];
    logic [ENTRIES-1:0] is_oldest;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
        end else if (touch_i) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx_i)
                    age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx_i])
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_old
        assign is_oldest[g] = (age_q[g] == OLDEST);
    end

    always_comb begin
        repl_idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (is_oldest[i]) repl_idx_o = IDX_W'(i);
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_i[i]) repl_idx_o = IDX_W'(i);
        end
    end

    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(is_oldest) == 1); // R7
endmodule

// File: rtl/victim_line_buffer.sv
module victim_line_buffer #(
    parameter int ENTRIES   = 4,
    parameter int LINE_AW   = 12,
    parameter int DATA_W    = 32,
    parameter bit MISS_MODE = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic               lk_valid_i,
    input  logic [LINE_AW-1:0] lk_addr_i,
    input  logic               ev_valid_i,
    input  logic [LINE_AW-1:0] ev_addr_i,
    input  logic [DATA_W-1:0]  ev_data_i,
    input  logic               ins_valid_i,
    input  logic [LINE_AW-1:0] fill_addr_i,
    input  logic [DATA_W-1:0]  fill_data_i,
    output logic               rsp_valid_o,
    output logic               rsp_hit_o,
    output logic [DATA_W-1:0]  rsp_data_o
);
    import vlb_pkg::*;

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    vlb_state_e          state_q, state_d;
    logic [ENTRIES-1:0]  ent_vld;
    logic [LINE_AW-1:0]  ent_tag [ENTRIES];
    logic [DATA_W-1:0]   ent_dat [ENTRIES];
    logic [DATA_W-1:0]   rsp_dat_q;

    logic                hit;
    logic [IDX_W-1:0]    hit_idx, repl_idx, touch_idx;
    logic                do_lk, do_ins, ins_ok, swap, touch;
    logic [LINE_AW-1:0]  ins_tag;
    logic [DATA_W-1:0]   ins_dat;

    vlb_match #(.ENTRIES(ENTRIES), .LINE_AW(LINE_AW)) u_match (
        .clk(clk), .rst_n(rst_n), .vld_i(ent_vld), .tag_i(ent_tag),
        .addr_i(lk_addr_i), .hit_o(hit), .idx_o(hit_idx));

    vlb_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch_i(touch), .touch_idx_i(touch_idx),
        .vld_i(ent_vld), .repl_idx_o(repl_idx));

    // Request decode: flush beats lookup, lookup beats insert.
    always_comb begin
        do_lk     = lk_valid_i && !flush_i;
        do_ins    = ins_valid_i && !lk_valid_i && !flush_i;
        ins_ok    = do_ins && (MISS_MODE || ev_valid_i);
        ins_tag   = MISS_MODE ? fill_addr_i : ev_addr_i;
        ins_dat   = MISS_MODE ? fill_data_i : ev_data_i;
        swap      = do_lk && hit && !MISS_MODE;
        touch     = (do_lk && hit && (MISS_MODE || ev_valid_i)) || ins_ok;
        touch_idx = do_lk ? hit_idx : repl_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            ent_vld <= '0;
        end else if (swap) begin
            ent_vld[hit_idx] <= ev_valid_i;
        end else if (ins_ok) begin
            ent_vld[repl_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (swap) begin
            ent_tag[hit_idx] <= ev_addr_i;
            ent_dat[hit_idx] <= ev_data_i;
        end else if (ins_ok) begin
            ent_tag[repl_idx] <= ins_tag;
            ent_dat[repl_idx] <= ins_dat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_dat_q <= '0;
        else if (do_lk) rsp_dat_q <= hit ? ent_dat[hit_idx] : '0;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_HIT_RSP, ST_MISS_RSP: begin
                if (do_lk) state_d = hit ? ST_HIT_RSP : ST_MISS_RSP;
                else       state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rsp_valid_o = 1'b0;
        rsp_hit_o   = 1'b0;
        rsp_data_o  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HIT_RSP: begin
                rsp_valid_o = 1'b1;
                rsp_hit_o   = 1'b1;
                rsp_data_o  = rsp_dat_q;
            end
            ST_MISS_RSP: rsp_valid_o = 1'b1;
            default: ;
        endcase
    end

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid_i && !flush_i) |=> rsp_valid_o); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_valid_i && !flush_i) |=> !rsp_valid_o); // R2
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (ent_vld == '0)); // R8
    AST_HIT_HAS_DATA_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit_o |-> rsp_valid_o); // R3
endmodule

// File: tb/victim_line_buffer_test.sv
module victim_line_buffer_test;
    localparam int N = 4;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam int NV = 24;
    localparam logic [AW-1:0] SEQ [NV] = '{
        12'h010, 12'h020, 12'h010, 12'h030, 12'h020, 12'h040, 12'h010, 12'h050,
        12'h060, 12'h020, 12'h011, 12'h021, 12'h011, 12'h070, 12'h030, 12'h080,
        12'h010, 12'h090, 12'h0A0, 12'h040, 12'h021, 12'h0B1, 12'h011, 12'h050};

    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
    logic lk_v = 1'b0, ev_v = 1'b0, ins_v = 1'b0;
    logic [AW-1:0] lk_a = '0, ev_a = '0, fill_a = '0;
    logic [DW-1:0] ev_d = '0, fill_d = '0;
    logic rv, rh, mrv, mrh;
    logic [DW-1:0] rd, mrd;
    logic mlk = 1'b0, mins = 1'b0;

    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    victim_line_buffer #(.ENTRIES(N), .LINE_AW(AW), .DATA_W(DW), .MISS_MODE(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .lk_valid_i(lk_v), .lk_addr_i(lk_a),
        .ev_valid_i(ev_v), .ev_addr_i(ev_a), .ev_data_i(ev_d), .ins_valid_i(ins_v),
        .fill_addr_i(fill_a), .fill_data_i(fill_d),
        .rsp_valid_o(rv), .rsp_hit_o(rh), .rsp_data_o(rd));

    victim_line_buffer #(.ENTRIES(N), .LINE_AW(AW), .DATA_W(DW), .MISS_MODE(1'b1)) uut_mc (
        .clk(clk), .rst_n(rst_n), .flush_i(1'b0), .lk_valid_i(mlk), .lk_addr_i(lk_a),
        .ev_valid_i(ev_v), .ev_addr_i(ev_a), .ev_data_i(ev_d), .ins_valid_i(mins),
        .fill_addr_i(fill_a), .fill_data_i(fill_d),
        .rsp_valid_o(mrv), .rsp_hit_o(mrh), .rsp_data_o(mrd));

    function automatic logic [DW-1:0] mem(input logic [AW-1:0] a);
        return {8'hA5, a, a} ^ 32'h0013_7000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model of the buffer
    logic          m_v [N];
    logic [AW-1:0] m_t [N];
    logic [DW-1:0] m_d [N];
    int            m_s [N];
    int            now = 0;

    task automatic m_lookup(input logic [AW-1:0] a, input logic evv, input logic [AW-1:0] eva,
                            input logic [DW-1:0] evd, output bit h, output logic [DW-1:0] d);
        h = 0; d = '0;
        for (int i = 0; i < N; i++) begin
            if (!h && m_v[i] && m_t[i] == a) begin
                h = 1; d = m_d[i];
                m_v[i] = evv; m_t[i] = eva; m_d[i] = evd;
                if (evv) begin now++; m_s[i] = now; end
            end
        end
    endtask

    task automatic m_insert(input logic evv, input logic [AW-1:0] eva, input logic [DW-1:0] evd);
        int k;
        if (!evv) return;
        k = 0;
        for (int i = 1; i < N; i++) if (m_s[i] < m_s[k]) k = i;
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) k = i;
        m_v[k] = 1; m_t[k] = eva; m_d[k] = evd; now++; m_s[k] = now;
    endtask

    task automatic do_lookup(input logic [AW-1:0] a, input logic evv, input logic [AW-1:0] eva,
                             input logic [DW-1:0] evd, input logic with_ins,
                             output logic h, output logic v, output logic [DW-1:0] d);
        @(negedge clk);
        lk_v = 1; lk_a = a; ev_v = evv; ev_a = eva; ev_d = evd; ins_v = with_ins;
        @(posedge clk);
        @(negedge clk);
        v = rv; h = rh; d = rd;
        lk_v = 0; ins_v = 0;
    endtask

    task automatic do_insert(input logic evv, input logic [AW-1:0] eva, input logic [DW-1:0] evd,
                             input logic [AW-1:0] fa, input logic [DW-1:0] fd);
        @(negedge clk);
        ins_v = 1; ev_v = evv; ev_a = eva; ev_d = evd; fill_a = fa; fill_d = fd;
        @(posedge clk);
        @(negedge clk);
        ins_v = 0;
        chk(rv == 1'b0, "R10 insert gives no response", DW'(rv), '0);
    endtask

    task automatic expect_lk(input logic [AW-1:0] a, input bit eh, input string req);
        logic h, v;
        logic [DW-1:0] d;
        do_lookup(a, 1'b0, '0, '0, 1'b0, h, v, d);
        chk(v && h == eh, req, DW'(h), DW'(eh));
        if (eh) chk(d == mem(a), req, d, mem(a));
    endtask

    task automatic report;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin : main
        logic dmv [4];
        logic [AW-1:0] dmt [4];
        logic [DW-1:0] dmd [4];
        logic h, v;
        logic [DW-1:0] d;
        bit eh;
        logic [DW-1:0] ed;

        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_s[i] = -N + i; m_t[i] = '0; m_d[i] = '0; end
        for (int s = 0; s < 4; s++) begin dmv[s] = 0; dmt[s] = '0; dmd[s] = '0; end

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rv == 1'b0, "R1 no response in reset", DW'(rv), '0);
        rst_n = 1;
        @(negedge clk);
        chk(rv == 1'b0, "R1 no response after reset", DW'(rv), '0);

        // Conflict-heavy walk against the reference model (R3, R4, R5, R7)
        for (int n = 0; n < NV; n++) begin
            logic [AW-1:0] a;
            int s;
            a = SEQ[n]; s = int'(a[1:0]);
            if (!(dmv[s] && dmt[s] == a)) begin
                m_lookup(a, dmv[s], dmt[s], dmd[s], eh, ed);
                do_lookup(a, dmv[s], dmt[s], dmd[s], 1'b0, h, v, d);
                chk(v == 1'b1, "R2 response valid", DW'(v), 1);
                chk(h == eh, "R3 hit flag vs model", DW'(h), DW'(eh));
                chk(d == ed, "R4 swapped data vs model", d, ed);
                if (!h) begin
                    m_insert(dmv[s], dmt[s], dmd[s]);
                    do_insert(dmv[s], dmt[s], dmd[s], a, mem(a));
                    d = mem(a);
                end
                dmv[s] = 1; dmt[s] = a; dmd[s] = d;
            end
        end

        // R8: flush empties; flush overrides same-cycle lookup
        do_insert(1'b1, 12'h300, mem(12'h300), '0, '0);
        @(negedge clk); flush = 1; lk_v = 1; lk_a = 12'h300;
        @(posedge clk); @(negedge clk);
        chk(rv == 1'b0, "R8 flush suppresses response", DW'(rv), 0);
        flush = 0; lk_v = 0;
        expect_lk(12'h300, 0, "R8 entry gone after flush");

        // R4: hit swaps lines
        do_insert(1'b1, 12'h301, mem(12'h301), '0, '0);
        do_lookup(12'h301, 1'b1, 12'h302, mem(12'h302), 1'b0, h, v, d);
        chk(h && d == mem(12'h301), "R4 hit returns line", d, mem(12'h301));
        expect_lk(12'h302, 1, "R4 evicted line entered");
        expect_lk(12'h301, 0, "R4 returned line left");

        // R5: invalid victim suppressed; fill not stored
        do_insert(1'b0, 12'h303, mem(12'h303), 12'h304, mem(12'h304));
        expect_lk(12'h303, 0, "R5 invalid victim suppressed");
        expect_lk(12'h304, 0, "R5 fill not stored in victim mode");

        // R9: insert with lookup dropped
        do_lookup(12'h305, 1'b1, 12'h306, mem(12'h306), 1'b1, h, v, d);
        chk(v && !h, "R9 lookup still answered", DW'(h), 0);
        expect_lk(12'h306, 0, "R9 concurrent insert dropped");

        // R7: LRU order
        @(negedge clk); flush = 1; @(negedge clk); flush = 0;
        do_insert(1'b1, 12'h400, mem(12'h400), '0, '0);
        do_insert(1'b1, 12'h401, mem(12'h401), '0, '0);
        do_insert(1'b1, 12'h402, mem(12'h402), '0, '0);
        do_insert(1'b1, 12'h403, mem(12'h403), '0, '0);
        do_lookup(12'h401, 1'b1, 12'h410, mem(12'h410), 1'b0, h, v, d);
        chk(h, "R7 fill hit", DW'(h), 1);
        do_insert(1'b1, 12'h404, mem(12'h404), '0, '0);
        do_insert(1'b1, 12'h405, mem(12'h405), '0, '0);
        expect_lk(12'h402, 0, "R7 second oldest evicted");
        expect_lk(12'h400, 0, "R7 oldest evicted");
        expect_lk(12'h403, 1, "R7 survivor kept");
        expect_lk(12'h410, 1, "R7 swapped-in line kept");
        expect_lk(12'h404, 1, "R7 newer insert kept");
        expect_lk(12'h405, 1, "R7 newest insert kept");

        // R6: miss-cache mode stores fill line, hit keeps it
        @(negedge clk); mins = 1; ev_v = 0; fill_a = 12'h500; fill_d = mem(12'h500);
        @(posedge clk); @(negedge clk); mins = 0;
        for (int r = 0; r < 2; r++) begin
            @(negedge clk); mlk = 1; lk_a = 12'h500; ev_v = 1; ev_a = 12'h600; ev_d = '0;
            @(posedge clk); @(negedge clk);
            chk(mrv && mrh && mrd == mem(12'h500), "R6 miss-cache entry hits and stays",
                mrd, mem(12'h500));
            mlk = 0;
        end
        @(negedge clk); mlk = 1; lk_a = 12'h600;
        @(posedge clk); @(negedge clk);
        chk(mrv && !mrh, "R6 no swap in miss-cache mode", DW'(mrh), 0);
        mlk = 0;

        report();
    end
endmodule